// File: doc/BRIEF.md
# Machine Status Flags and Fetch Dispatcher

This block keeps the control flags of a small word-oriented processor and decides, for every fetched 16-bit word, where it goes. A word whose top bit is clear is an ordinary instruction and is passed on to the instruction register. A word whose top bit is set is a call into firmware. Its low 15 bits are an entry address, which is loaded into the firmware counter. The block then enters firmware mode and switches the active-counter selector to the firmware counter. A later return instruction leaves firmware mode and restores the selector that was active before the call.

The block also owns the run/halt state. Halt can be requested by the user, by an instruction or by an error input, and a run request clears it. While the machine runs, the advance enable is high on every cycle. While it is halted, the enable rises only for a single cycle on each press of the step button. The raw button is synchronised and edge-detected. A front-panel mode switch puts the machine into input mode, where execution stops and front-panel writes are allowed. A carry flag records bit 16 of each arithmetic result that is reported to the block.

Top module: `ctl_flags_dispatch`

## Requirements
- R1: After reset, halted=1, input_mode=0, fw_mode=0, carry=0, active_sel=0 (program counter index), and ir_load=0 and fw_load=0.
- R2: A fetch (fetch_valid=1, not input mode) with bit 15 = 0 gives ir_load=1 and ir_word equal to the word on the next cycle, with fw_load=0. This holds in firmware mode too.
- R3: A fetch with bit 15 = 1 gives, on the next cycle, fw_load=1, fw_addr = bits 14:0, fw_mode=1 and active_sel=1 (firmware counter index), with ir_load=0.
- R4: ret_instr while fw_mode=1 clears fw_mode on the next cycle and restores active_sel to its value before the outermost call. ret_instr while fw_mode=0 has no effect.
- R5: A call and a return in the same cycle resolve in favour of the call. A call made while already in firmware mode keeps the saved selector unchanged.
- R6: halt_user, halt_instr or err_in sets halted on the next cycle, and run_req clears it. If a set request and run_req come together, halted ends up 1.
- R7: With halted=0 and input_mode=0, advance_en=1 on every cycle. With halted=1, advance_en is 0 except for exactly one cycle per rising edge of step_btn, no matter how long the button is held.
- R8: input_mode follows panel_sw one cycle later. While it is 1, advance_en=0, panel_wr_en=1, and fetches and returns are ignored.
- R9: On arith_wr=1 the carry flag takes arith_res[16] on the next cycle. Otherwise it holds its value.
- R10: sel_wr writes sel_val into active_sel on the next cycle when fw_mode=0. It is ignored while fw_mode=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_btn | input | 1 | Raw single-step button, asynchronous |
| run_req | input | 1 | Clear halt |
| halt_user | input | 1 | User halt request |
| halt_instr | input | 1 | Halt from an instruction |
| err_in | input | 1 | Error, forces halt |
| panel_sw | input | 1 | Front-panel input-mode switch |
| arith_wr | input | 1 | Arithmetic result valid |
| arith_res | input | 17 | Arithmetic result including carry bit |
| fetch_valid | input | 1 | Fetched word present |
| fetch_word | input | 16 | Fetched word |
| ret_instr | input | 1 | Return instruction seen |
| sel_wr | input | 1 | Write active-counter selector |
| sel_val | input | 4 | Selector value to write |
| advance_en | output | 1 | Enable for one fetch/execute step |
| halted | output | 1 | Halt flag |
| input_mode | output | 1 | Input-mode flag |
| panel_wr_en | output | 1 | Front-panel writes allowed |
| carry | output | 1 | Carry flag |
| ir_load | output | 1 | Load instruction register |
| ir_word | output | 16 | Word for instruction register |
| fw_load | output | 1 | Load firmware counter |
| fw_addr | output | 15 | Firmware entry address |
| fw_mode | output | 1 | Firmware (instruction) mode flag |
| active_sel | output | 4 | Index of the counter driving the address |

## Verification
Two pairs of events can land in the same cycle. The first is a firmware call and a return. The bench sends a top-bit-set fetch together with ret_instr while already in firmware mode, and expects firmware mode to stay on with the firmware index selected. A following return must then still bring back the selector saved before the first call. The second pair is a halt request and run_req raised on the same edge, which must leave the machine halted.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  // Next halt state: any set source beats a run request.
  function automatic logic next_halt(input logic cur, input logic set_any, input logic run);
    if (set_any)  return 1'b1;
    else if (run) return 1'b0;
    else          return cur;
  endfunction

  // Advance gate: free-running when not halted, step pulse when halted, never in input mode.
  function automatic logic adv_gate(input logic hlt, input logic inmode, input logic step);
    if (inmode)   return 1'b0;
    else if (hlt) return step;
    else          return 1'b1;
  endfunction

endpackage

// File: rtl/cfd_step_edge.sv
module cfd_step_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic pulse
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], raw};
  end

  assign pulse = sh[STAGES-1] & ~sh[STAGES];

  // R7: a press yields a single-cycle pulse
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/cfd_flags.sv
module cfd_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_req,
  input  logic         halt_user,
  input  logic         halt_instr,
  input  logic         err_in,
  input  logic         panel_sw,
  input  logic         arith_wr,
  input  logic [W:0]   arith_res,
  output logic         halted,
  output logic         input_mode,
  output logic         carry
);
  import cfd_pkg::*;

  logic halt_set_ev;
  assign halt_set_ev = halt_user | halt_instr | err_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted     <= 1'b1;
      input_mode <= 1'b0;
      carry      <= 1'b0;
    end else begin
      halted     <= next_halt(halted, halt_set_ev, run_req);
      input_mode <= panel_sw;
      if (arith_wr) carry <= arith_res[W];
    end
  end

  // R6: set requests win and take effect next cycle
  assert_halt_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_set_ev |=> halted);
  assert_halt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_req && !halt_set_ev) |=> !halted);
  // R9: carry captures the top result bit
  assert_carry_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arith_wr |=> (carry == $past(arith_res[W])));
  assert_carry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !arith_wr |=> $stable(carry));
endmodule

// File: rtl/cfd_dispatch.sv
module cfd_dispatch #(
  parameter int              W      = 16,
  parameter int              SEL_W  = 4,
  parameter logic [SEL_W-1:0] FW_IDX = 1,
  parameter logic [SEL_W-1:0] PC_IDX = 0,
  localparam int             AW     = W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_ok,
  input  logic             fetch_valid,
  input  logic [W-1:0]     fetch_word,
  input  logic             ret_instr,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_val,
  output logic             ir_load,
  output logic [W-1:0]     ir_word,
  output logic             fw_load,
  output logic [AW-1:0]    fw_addr,
  output logic             fw_mode,
  output logic [SEL_W-1:0] active_sel
);
  logic             call_ev, op_ev, ret_ev;
  logic [SEL_W-1:0] saved_sel;

  assign call_ev = exec_ok & fetch_valid &  fetch_word[W-1];
  assign op_ev   = exec_ok & fetch_valid & ~fetch_word[W-1];
  assign ret_ev  = exec_ok & ret_instr & fw_mode & ~call_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_load    <= 1'b0;
      ir_word    <= '0;
      fw_load    <= 1'b0;
      fw_addr    <= '0;
      fw_mode    <= 1'b0;
      active_sel <= PC_IDX;
      saved_sel  <= PC_IDX;
    end else begin
      ir_load <= op_ev;
      fw_load <= call_ev;
      if (op_ev)   ir_word <= fetch_word;
      if (call_ev) begin
        fw_addr    <= fetch_word[AW-1:0];
        fw_mode    <= 1'b1;
        active_sel <= FW_IDX;
        if (!fw_mode) saved_sel <= active_sel;
      end else if (ret_ev) begin
        fw_mode    <= 1'b0;
        active_sel <= saved_sel;
      end else if (sel_wr && !fw_mode) begin
        active_sel <= sel_val;
      end
    end
  end

  // R2/R3: at most one destination per fetch
  assert_one_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ir_load, fw_load}));
  // R3: a firmware load always comes with the mode and selector switch
  assert_call_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fw_load |-> (fw_mode && active_sel == FW_IDX));
  // R4: mode only drops after a return request
  assert_leave_on_ret_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fw_mode) |-> $past(ret_instr));
  // R5: call beats return in the same cycle
  assert_call_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (call_ev && ret_instr) |=> fw_mode);
  // R10: selector frozen by writes during firmware mode
  assert_sel_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_mode && !ret_ev && !call_ev) |=> $stable(active_sel));
endmodule

// File: rtl/ctl_flags_dispatch.sv
module ctl_flags_dispatch #(
  parameter int               W       = 16,
  parameter int               SEL_W   = 4,
  parameter logic [SEL_W-1:0] FW_IDX  = 1,
  parameter logic [SEL_W-1:0] PC_IDX  = 0,
  parameter int               SYNC_ST = 2,
  localparam int              AW      = W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_btn,
  input  logic             run_req,
  input  logic             halt_user,
  input  logic             halt_instr,
  input  logic             err_in,
  input  logic             panel_sw,
  input  logic             arith_wr,
  input  logic [W:0]       arith_res,
  input  logic             fetch_valid,
  input  logic [W-1:0]     fetch_word,
  input  logic             ret_instr,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_val,
  output logic             advance_en,
  output logic             halted,
  output logic             input_mode,
  output logic             panel_wr_en,
  output logic             carry,
  output logic             ir_load,
  output logic [W-1:0]     ir_word,
  output logic             fw_load,
  output logic [AW-1:0]    fw_addr,
  output logic             fw_mode,
  output logic [SEL_W-1:0] active_sel
);
  import cfd_pkg::*;

  logic step_pulse;

  cfd_step_edge #(.STAGES(SYNC_ST)) u_step (
    .clk(clk), .rst_n(rst_n), .raw(step_btn), .pulse(step_pulse)
  );

  cfd_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .halt_user(halt_user),
    .halt_instr(halt_instr), .err_in(err_in), .panel_sw(panel_sw),
    .arith_wr(arith_wr), .arith_res(arith_res),
    .halted(halted), .input_mode(input_mode), .carry(carry)
  );

  cfd_dispatch #(.W(W), .SEL_W(SEL_W), .FW_IDX(FW_IDX), .PC_IDX(PC_IDX)) u_disp (
    .clk(clk), .rst_n(rst_n), .exec_ok(~input_mode),
    .fetch_valid(fetch_valid), .fetch_word(fetch_word), .ret_instr(ret_instr),
    .sel_wr(sel_wr), .sel_val(sel_val),
    .ir_load(ir_load), .ir_word(ir_word), .fw_load(fw_load), .fw_addr(fw_addr),
    .fw_mode(fw_mode), .active_sel(active_sel)
  );

  assign advance_en  = adv_gate(halted, input_mode, step_pulse);
  assign panel_wr_en = input_mode;

  // R8: no execution advance in input mode
  assert_no_adv_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    input_mode |-> !advance_en);
  // R7: while halted, an advance never lasts two cycles
  assert_step_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted) && advance_en) |=> !(halted && advance_en));
  // R7: free-running when released
  assert_run_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !input_mode) |-> advance_en);
endmodule

// File: tb/ctl_flags_dispatch_tb.sv
`timescale 1ns/1ps
module ctl_flags_dispatch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_btn = 0, run_req = 0, halt_user = 0, halt_instr = 0, err_in = 0, panel_sw = 0;
  logic arith_wr = 0;
  logic [16:0] arith_res = '0;
  logic fetch_valid = 0;
  logic [15:0] fetch_word = '0;
  logic ret_instr = 0, sel_wr = 0;
  logic [3:0] sel_val = '0;
  logic advance_en, halted, input_mode, panel_wr_en, carry, ir_load, fw_load, fw_mode;
  logic [15:0] ir_word;
  logic [14:0] fw_addr;
  logic [3:0] active_sel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ctl_flags_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .step_btn(step_btn), .run_req(run_req),
    .halt_user(halt_user), .halt_instr(halt_instr), .err_in(err_in),
    .panel_sw(panel_sw), .arith_wr(arith_wr), .arith_res(arith_res),
    .fetch_valid(fetch_valid), .fetch_word(fetch_word), .ret_instr(ret_instr),
    .sel_wr(sel_wr), .sel_val(sel_val), .advance_en(advance_en), .halted(halted),
    .input_mode(input_mode), .panel_wr_en(panel_wr_en), .carry(carry),
    .ir_load(ir_load), .ir_word(ir_word), .fw_load(fw_load), .fw_addr(fw_addr),
    .fw_mode(fw_mode), .active_sel(active_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_in();
    fetch_valid = 0; ret_instr = 0; sel_wr = 0; run_req = 0; halt_user = 0;
    halt_instr = 0; err_in = 0; arith_wr = 0;
  endtask

  // Vector: {valid, word[15:0], ret, exp_ir, exp_fw, exp_mode, exp_sel[3:0]}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'h1234, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0},  // R2 plain op
    {1'b1, 16'h8ABC, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1},  // R3 call
    {1'b1, 16'h0042, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1},  // R2 op in firmware
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R4 return
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R4 stray return
    {1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1},  // R3 max address
    {1'b1, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1},  // R5 call+return
    {1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}   // R4 return after R5
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) tick();
    // R1 reset state
    chk("R1 halted", halted, 1);
    chk("R1 input_mode", input_mode, 0);
    chk("R1 fw_mode", fw_mode, 0);
    chk("R1 carry", carry, 0);
    chk("R1 active_sel", active_sel, 0);
    chk("R1 loads", {ir_load, fw_load}, 0);
    chk("R1 advance_en", advance_en, 0);
    rst_n = 1;
    tick();

    // Vector table walk (R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      fetch_valid = v[24]; fetch_word = v[23:8]; ret_instr = v[7];
      tick();
      clear_in();
      chk($sformatf("R2 ir_load vec%0d", i), ir_load, v[6]);
      if (v[6]) chk($sformatf("R2 ir_word vec%0d", i), ir_word, v[23:8]);
      chk($sformatf("R3 fw_load vec%0d", i), fw_load, v[5]);
      if (v[5]) chk($sformatf("R3 fw_addr vec%0d", i), fw_addr, {17'd0, v[22:8]});
      chk($sformatf("R4 fw_mode vec%0d", i), fw_mode, v[4]);
      chk($sformatf("R5 active_sel vec%0d", i), active_sel, v[3:0]);
    end

    // R10 selector write, then nested call keeps saved index (R5)
    sel_wr = 1; sel_val = 4'd3; tick(); clear_in();
    chk("R10 sel write", active_sel, 3);
    fetch_valid = 1; fetch_word = 16'h8010; tick(); clear_in();
    chk("R3 call sel", active_sel, 1);
    sel_wr = 1; sel_val = 4'd7; tick(); clear_in();
    chk("R10 sel ignored in fw", active_sel, 1);
    fetch_valid = 1; fetch_word = 16'h8020; tick(); clear_in();
    ret_instr = 1; tick(); clear_in();
    chk("R5 nested restore", active_sel, 3);
    chk("R4 mode cleared", fw_mode, 0);

    // R7 step while halted
    cnt = 0;
    step_btn = 1;
    for (int k = 0; k < 8; k++) begin tick(); cnt += advance_en; end
    chk("R7 one step per press", cnt, 1);
    step_btn = 0;
    cnt = 0;
    for (int k = 0; k < 5; k++) begin tick(); cnt += advance_en; end
    chk("R7 no step after release", cnt, 0);

    // R6 run / halt
    run_req = 1; tick(); clear_in();
    chk("R6 run clears", halted, 0);
    chk("R7 free advance", advance_en, 1);
    halt_user = 1; run_req = 1; tick(); clear_in();
    chk("R6 set wins over run", halted, 1);
    run_req = 1; tick(); clear_in();
    err_in = 1; tick(); clear_in();
    chk("R6 error halts", halted, 1);
    run_req = 1; tick(); clear_in();
    halt_instr = 1; tick(); clear_in();
    chk("R6 instr halts", halted, 1);
    run_req = 1; tick(); clear_in();

    // R8 input mode
    panel_sw = 1; tick();
    chk("R8 input_mode", input_mode, 1);
    chk("R8 panel_wr_en", panel_wr_en, 1);
    chk("R8 no advance", advance_en, 0);
    fetch_valid = 1; fetch_word = 16'h8123; tick(); clear_in();
    chk("R8 fetch ignored", {ir_load, fw_load, fw_mode}, 0);
    fetch_valid = 1; fetch_word = 16'h0123; tick(); clear_in();
    chk("R8 op ignored", ir_load, 0);
    panel_sw = 0; tick();
    chk("R8 leave input", advance_en, 1);

    // R9 carry
    arith_wr = 1; arith_res = 17'h10000; tick(); clear_in();
    chk("R9 carry set", carry, 1);
    arith_res = 17'h0FFFF; tick();
    chk("R9 carry hold", carry, 1);
    arith_wr = 1; tick(); clear_in();
    chk("R9 carry clear", carry, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule